// File: doc/BRIEF.md
# Watchdog Pulse and PWM Timer

A 24-bit up-counting timer driven through a write-only register port. Software sets a start value, a match value and a control word. The live count, the two sticky status flags and two level interrupts are visible on dedicated outputs. Counting advances on a timer clock. The timer clock is either an internal tick at half the system clock rate or a one-cycle pulse supplied by an external prescaler.

The same counter serves two pin behaviours. In watchdog-pulse mode, rolling over past the all-ones value drives a pulse on the timer pin. The pulse lasts exactly one timer clock, and its polarity is programmable. In PWM mode, the pin turns active when the count reaches the match value. At rollover the pin turns inactive again and the counter restarts from the start value, so the match value sets the duty cycle.

Top module: `wdt_pwm_timer`

## Requirements
- R1: After reset the count is 0, both flags and both interrupts are 0, and the pin is 1 (inactive, because the invert bit resets to 0).
- R2: A control write that sets the enable bit (bit 0) while it was clear zeroes the count. The first timer clock afterwards copies the start register (address 1) into the count, and each later timer clock adds one.
- R3: With clock-select (control bit 5) clear, a timer clock occurs on every second system clock while enabled, and the external tick is ignored. With clock-select set, only cycles with the external tick high count.
- R4: When a timer clock brings the count to the match register (address 2), the match flag is set. The match interrupt equals that flag ANDed with control bit 3.
- R5: With the reload bit (control bit 1) set, the timer clock after a match copies the start value into the count. With the reload bit clear, counting continues by one.
- R6: A timer clock at count 0xFFFFFF sets the overflow flag. The overflow interrupt equals that flag ANDed with control bit 4. Outside PWM mode the count wraps to 0.
- R7: In watchdog-pulse mode (control bits 9:6 = 1001), an overflow drives the pin to the invert bit (control bit 2) for exactly one timer clock. The pin then returns to the opposite level.
- R8: Writing the start register while enabled loads the written value into the count at that same clock edge.
- R9: In PWM mode (control bits 9:6 = 0111), a match toggles the pin to its active level. An overflow returns the pin to the inactive level and reloads the count from the start value. The reload bit has no effect in PWM mode.
- R10: While the enable bit is clear, the count holds its value and the pin sits at the inverse of the invert bit.
- R11: Writing 1 to bit 0 (match) or bit 1 (overflow) at address 3 clears that flag. Other flags are unchanged. If a flag is set and cleared in the same cycle, setting wins.
- R12: The count output always shows the live counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 start, 2 match, 3 flag clear |
| wr_data | input | 24 | Write data |
| ext_tick | input | 1 | External prescaler tick, one cycle wide |
| count | output | 24 | Live counter value |
| cmp_flag | output | 1 | Sticky match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_irq | output | 1 | Match interrupt level |
| ovf_irq | output | 1 | Overflow interrupt level |
| tmr_pin | output | 1 | Timer pin output |

## Verification
Each fault in the counter state shows on the count output one system clock after the timer clock that caused it. For example, a missed first-load or a stuck reload shows as a wrong count right after the next tick. A wrong flag-set or flag-clear edge shows on the flag and interrupt outputs in the cycle after the hit or the clear write. Faults in the pin state show up within one timer clock, as a pulse of the wrong width or polarity, or as a PWM level that fails to flip at the match or at rollover.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int CTL_BITS = 10;
   localparam logic [3:0] MODE_WDOG = 4'b1001;
   localparam logic [3:0] MODE_PWM  = 4'b0111;
   localparam logic [1:0] A_CTL  = 2'd0;
   localparam logic [1:0] A_LOAD = 2'd1;
   localparam logic [1:0] A_CMP  = 2'd2;
   localparam logic [1:0] A_STAT = 2'd3;

   typedef struct packed {
      logic [3:0] mode;
      logic       csel;
      logic       oie;
      logic       cie;
      logic       inv;
      logic       rld;
      logic       en;
   } ctl_t;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int INT_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ext_sel,
   input  logic ext_tick,
   output logic tick
);
   generate
      if (INT_DIV < 1) begin : g_bad_div
         $error("INT_DIV must be at least 1");
      end
      if (INT_DIV == 1) begin : g_nodiv
         assign tick = en & (ext_sel ? ext_tick : 1'b1);
      end else begin : g_div
         localparam int DW = $clog2(INT_DIV);
         localparam logic [DW-1:0] LAST = DW'(INT_DIV - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 div_q <= '0;
            else if (!en || ext_sel)    div_q <= '0;
            else if (div_q == LAST)     div_q <= '0;
            else                        div_q <= div_q + 1'b1;
         end
         assign tick = en & (ext_sel ? ext_tick : (div_q == LAST));
      end
   endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             en_rise,
   input  logic             tick,
   input  logic             reload_en,
   input  logic             mode_pwm,
   input  logic             ld_force,
   input  logic [CNT_W-1:0] ld_val,
   input  logic [CNT_W-1:0] load_q,
   input  logic [CNT_W-1:0] cmp_q,
   output logic [CNT_W-1:0] cnt,
   output logic             cmp_hit,
   output logic             ovf_hit
);
   logic [CNT_W-1:0] cnt_q, nxt;
   logic [CNT_W:0]   inc;
   logic             first_q, rld_q, step;

   assign step = tick & en;
   assign inc  = {1'b0, cnt_q} + 1'b1;

   always_comb begin
      nxt     = cnt_q;
      ovf_hit = 1'b0;
      if (step) begin
         if (first_q || rld_q) begin
            nxt = load_q;
         end else if (inc[CNT_W]) begin
            ovf_hit = 1'b1;
            nxt     = mode_pwm ? load_q : '0;
         end else begin
            nxt = inc[CNT_W-1:0];
         end
      end
   end

   assign cmp_hit = step & (nxt == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         first_q <= 1'b0;
         rld_q   <= 1'b0;
      end else if (en_rise) begin
         cnt_q   <= '0;
         first_q <= 1'b1;
         rld_q   <= 1'b0;
      end else if (ld_force) begin
         cnt_q   <= ld_val;
         first_q <= 1'b0;
         rld_q   <= 1'b0;
      end else if (step) begin
         cnt_q   <= nxt;
         first_q <= 1'b0;
         rld_q   <= cmp_hit & reload_en;
      end
   end

   assign cnt = cnt_q;

   p_first_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && first_q && !en_rise && !ld_force) |=> (cnt_q == $past(load_q)));
   p_hold_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !en_rise) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_pin_out.sv
module tmr_pin_out (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic mode_wd,
   input  logic mode_pwm,
   input  logic inv,
   input  logic tick,
   input  logic cmp_hit,
   input  logic ovf_hit,
   output logic pin
);
   logic act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                act_q <= 1'b0;
      else if (!en)              act_q <= 1'b0;
      else if (mode_wd) begin
         if (ovf_hit)            act_q <= 1'b1;
         else if (tick)          act_q <= 1'b0;
      end else if (mode_pwm) begin
         if (ovf_hit)            act_q <= 1'b0;
         else if (cmp_hit)       act_q <= ~act_q;
      end else                   act_q <= 1'b0;
   end

   assign pin = ~((en & act_q) ^ inv);

   p_pulse_one_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode_wd && act_q && tick && !ovf_hit) |=> !act_q);
endmodule

// File: rtl/wdt_pwm_timer.sv
module wdt_pwm_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W   = 24,
   parameter int INT_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             ext_tick,
   output logic [CNT_W-1:0] count,
   output logic             cmp_flag,
   output logic             ovf_flag,
   output logic             cmp_irq,
   output logic             ovf_irq,
   output logic             tmr_pin
);
   generate
      if (CNT_W < CTL_BITS) begin : g_bad_width
         $error("CNT_W must cover the control word");
      end
   endgenerate

   ctl_t             ctl_q, ctl_new;
   logic [CNT_W-1:0] load_q, cmp_q;
   logic             ctl_wr, ld_wr, cmp_wr, st_wr;
   logic             en_rise, ld_force, tick, cmp_hit, ovf_hit;
   logic             mode_wd, mode_pwm, cflag_q, oflag_q;

   assign ctl_wr  = wr_en & (wr_addr == A_CTL);
   assign ld_wr   = wr_en & (wr_addr == A_LOAD);
   assign cmp_wr  = wr_en & (wr_addr == A_CMP);
   assign st_wr   = wr_en & (wr_addr == A_STAT);
   assign ctl_new = ctl_t'(wr_data[CTL_BITS-1:0]);
   assign en_rise = ctl_wr & ctl_new.en & ~ctl_q.en;
   assign ld_force = ld_wr & ctl_q.en;
   assign mode_wd  = (ctl_q.mode == MODE_WDOG);
   assign mode_pwm = (ctl_q.mode == MODE_PWM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         load_q <= '0;
         cmp_q  <= '0;
      end else begin
         if (ctl_wr) ctl_q  <= ctl_new;
         if (ld_wr)  load_q <= wr_data;
         if (cmp_wr) cmp_q  <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cflag_q <= 1'b0;
         oflag_q <= 1'b0;
      end else begin
         cflag_q <= cmp_hit | (cflag_q & ~(st_wr & wr_data[0]));
         oflag_q <= ovf_hit | (oflag_q & ~(st_wr & wr_data[1]));
      end
   end

   tmr_tick_gen #(.INT_DIV(INT_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .ext_sel(ctl_q.csel),
      .ext_tick(ext_tick), .tick(tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .en_rise(en_rise), .tick(tick),
      .reload_en(ctl_q.rld & ~mode_pwm), .mode_pwm(mode_pwm),
      .ld_force(ld_force), .ld_val(wr_data), .load_q(load_q), .cmp_q(cmp_q),
      .cnt(count), .cmp_hit(cmp_hit), .ovf_hit(ovf_hit)
   );

   tmr_pin_out u_pin (
      .clk(clk), .rst_n(rst_n), .en(ctl_q.en), .mode_wd(mode_wd),
      .mode_pwm(mode_pwm), .inv(ctl_q.inv), .tick(tick), .cmp_hit(cmp_hit),
      .ovf_hit(ovf_hit), .pin(tmr_pin)
   );

   assign cmp_flag = cflag_q;
   assign ovf_flag = oflag_q;
   assign cmp_irq  = cflag_q & ctl_q.cie;
   assign ovf_irq  = oflag_q & ctl_q.oie;

   p_cmp_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit |=> cmp_flag);
   p_ovf_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_hit |=> ovf_flag);
   p_idle_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q.en |-> (tmr_pin == !ctl_q.inv));
endmodule

// File: tb/wdt_pwm_timer_tb.sv
module wdt_pwm_timer_tb;
   localparam int W = 24;
   localparam int K_CNT = 0, K_PIN = 1, K_CF = 2, K_OF = 3, K_CI = 4, K_OI = 5;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, ext_tick = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] count;
   logic cmp_flag, ovf_flag, cmp_irq, ovf_irq, tmr_pin;

   typedef struct { int kind; logic [W-1:0] exp; string req; } item_t;
   item_t sb_q[$];
   event  chk_ev;
   int n_vec = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   wdt_pwm_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ext_tick(ext_tick), .count(count),
      .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .cmp_irq(cmp_irq),
      .ovf_irq(ovf_irq), .tmr_pin(tmr_pin)
   );

   function automatic logic [W-1:0] port_val(int kind);
      case (kind)
         K_CNT:   return count;
         K_PIN:   return W'(tmr_pin);
         K_CF:    return W'(cmp_flag);
         K_OF:    return W'(ovf_flag);
         K_CI:    return W'(cmp_irq);
         default: return W'(ovf_irq);
      endcase
   endfunction

   initial begin : monitor
      forever begin
         @(chk_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            logic [W-1:0] act;
            it  = sb_q.pop_front();
            act = port_val(it.kind);
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic expect_v(int kind, logic [W-1:0] exp, string req);
      item_t it;
      it.kind = kind; it.exp = exp; it.req = req;
      sb_q.push_back(it);
      -> chk_ev;
      #1;
   endtask

   task automatic wr(logic [1:0] a, logic [W-1:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic tk(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ext_tick = 1'b1;
         @(negedge clk); ext_tick = 1'b0;
      end
   endtask

   function automatic logic [W-1:0] mk_ctl(bit en, bit rld, bit inv, bit cie,
                                           bit oie, bit csel, logic [3:0] mode);
      return W'({mode, csel, oie, cie, inv, rld, en});
   endfunction

   initial begin : watchdog
      #(20 * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      // R1 reset state
      expect_v(K_CNT, 0, "R1"); expect_v(K_CF, 0, "R1"); expect_v(K_OF, 0, "R1");
      expect_v(K_CI, 0, "R1"); expect_v(K_OI, 0, "R1"); expect_v(K_PIN, 1, "R1");
      rst_n = 1'b1;
      @(negedge clk);

      // Watchdog mode, external ticks, invert=1
      wr(2'd1, 24'hFFFFFC);
      wr(2'd2, 24'hFFFFFE);
      wr(2'd0, mk_ctl(1, 0, 1, 1, 1, 1, 4'b1001));
      expect_v(K_CNT, 0, "R2 enable clears");
      expect_v(K_PIN, 0, "R10 inactive level inv=1");
      tk(1); expect_v(K_CNT, 24'hFFFFFC, "R2 first load");
      tk(1); expect_v(K_CNT, 24'hFFFFFD, "R2 increment R12");
      repeat (3) @(negedge clk);
      expect_v(K_CNT, 24'hFFFFFD, "R3 no ext tick no count");
      tk(1); expect_v(K_CF, 1, "R4 match flag"); expect_v(K_CI, 1, "R4 match irq");
      tk(1); expect_v(K_CNT, 24'hFFFFFF, "R5 reload clear continues");
      expect_v(K_PIN, 0, "R7 no pulse before overflow");
      tk(1); expect_v(K_CNT, 0, "R6 wrap"); expect_v(K_OF, 1, "R6 ovf flag");
      expect_v(K_OI, 1, "R6 ovf irq"); expect_v(K_PIN, 1, "R7 pulse active");
      repeat (3) @(negedge clk);
      expect_v(K_PIN, 1, "R7 pulse held until next tick");
      tk(1); expect_v(K_PIN, 0, "R7 pulse one tick wide");
      expect_v(K_CNT, 1, "R6 count after wrap");
      wr(2'd3, 24'h1);
      expect_v(K_CF, 0, "R11 clear match"); expect_v(K_CI, 0, "R11 irq drops");
      expect_v(K_OF, 1, "R11 ovf kept");

      // R8 forced load
      wr(2'd1, 24'h000100);
      expect_v(K_CNT, 24'h000100, "R8 load while enabled");

      // R5 reload on match
      wr(2'd2, 24'h000102);
      wr(2'd0, mk_ctl(1, 1, 1, 1, 1, 1, 4'b1001));
      tk(2); expect_v(K_CNT, 24'h000102, "R5 reaches match");
      expect_v(K_CF, 1, "R4 flag second match");
      tk(1); expect_v(K_CNT, 24'h000100, "R5 reload after match");

      // R10 disable
      wr(2'd0, mk_ctl(0, 1, 1, 1, 1, 1, 4'b1001));
      expect_v(K_PIN, 0, "R10 pin inactive");
      tk(3); expect_v(K_CNT, 24'h000100, "R10 count holds");
      wr(2'd3, 24'h3);
      expect_v(K_OF, 0, "R11 clear ovf");

      // R9 PWM mode, invert=0
      wr(2'd1, 24'hFFFFF8);
      wr(2'd2, 24'hFFFFFC);
      wr(2'd0, mk_ctl(1, 1, 0, 0, 0, 1, 4'b0111));
      expect_v(K_PIN, 1, "R9 idle high");
      tk(1); expect_v(K_CNT, 24'hFFFFF8, "R9 start");
      expect_v(K_PIN, 1, "R9 inactive before match");
      tk(4); expect_v(K_PIN, 0, "R9 active at match");
      expect_v(K_CI, 0, "R4 irq masked");
      tk(1); expect_v(K_CNT, 24'hFFFFFD, "R9 reload bit ignored");
      tk(2); expect_v(K_PIN, 0, "R9 active until overflow");
      tk(1); expect_v(K_CNT, 24'hFFFFF8, "R9 overflow reload");
      expect_v(K_PIN, 1, "R9 back inactive");
      expect_v(K_OF, 1, "R6 flag in PWM"); expect_v(K_OI, 0, "R6 irq masked");

      // R3 internal divide-by-two
      wr(2'd0, mk_ctl(0, 0, 0, 0, 0, 0, 4'b1001));
      wr(2'd1, 24'h000005);
      wr(2'd0, mk_ctl(1, 0, 0, 0, 0, 0, 4'b1001));
      expect_v(K_CNT, 0, "R3 after enable");
      @(negedge clk); expect_v(K_CNT, 0, "R3 no tick first clock");
      @(negedge clk); expect_v(K_CNT, 5, "R3 tick second clock");
      @(negedge clk); expect_v(K_CNT, 5, "R3 hold odd clock");
      @(negedge clk); expect_v(K_CNT, 6, "R3 tick fourth clock");

      #5;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule